// File: doc/BRIEF.md
# Serial Port Register File and Interrupt Identification

This block is the host-visible side of a 16550-style serial port. A byte-wide bus with a 3-bit offset reaches eight register slots: data, interrupt enable, interrupt identification / FIFO control, line control, modem control, line status, modem status and scratch. Bit 7 of line control switches offsets 0 and 1 over to a 16-bit divisor latch. The block does no bit-level serialisation and generates no baud clock. Received bytes arrive as parallel words with a valid strobe and go into a small queue. Each byte the host writes to the data register leaves the block as a one-cycle strobe.

Four interrupt sources are tracked as pending flags: character timeout, receive data, transmit holding empty and modem status. One identification code is selected from them in a fixed priority order. A registered, active-high IRQ output follows whether any enabled source is pending. Reads have side effects, and these take effect on the clock edge of the read cycle: popping the receive queue, clearing a transmit-empty interrupt that has just been reported, and clearing the modem delta bits. Read data is combinational from the current state while the read strobe is high.

Top module: `serial_regfile`

## Requirements
- R1: After reset, the enable register reads 0x00, identification reads 0x01, line status reads 0x60, irq and tx_valid are low, and a transmit-empty interrupt is already pending.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The data path and the enable register are left untouched.
- R3: A write to the enable register (offset 1, line control bit 7 clear) keeps only bits 3:0. A read returns those bits with bits 7:4 as zero.
- R4: Identification bits 3:0 report the highest-priority enabled pending source: timeout 0xC, then receive data 0x4, then transmit empty 0x2, then modem status 0x0. Enable bit 0 gates both timeout and receive data, bit 1 gates transmit empty and bit 3 gates modem status. With nothing active the code is 0x1.
- R5: irq is a registered level that is high exactly when the code is not 0x1. It changes one clock after the state that causes the change.
- R6: Identification bits 7:6 read as 1 when FIFO control bit 0 (written at offset 2) is set, and as 0 otherwise. Reading identification while it reports 0x2 clears the pending transmit-empty interrupt.
- R7: A received byte sets line status bit 0. It makes the timeout interrupt pending if FIFO control bit 0 is set, and the receive-data interrupt pending otherwise.
- R8: A data read (line control bit 7 clear) returns the oldest queued byte in arrival order, or 0x00 when the queue is empty. A read that leaves the queue empty clears line status bit 0 and both receive interrupts.
- R9: A data write (line control bit 7 clear) drives tx_valid high for exactly one cycle, with tx_byte equal to the written byte, in the cycle after the write. It also makes transmit empty pending.
- R10: A write to the enable register that takes bit 1 from 0 to 1 makes transmit empty pending again.
- R11: Writes to offset 5 have no effect. Offsets 3, 4 and 7 read back the last byte written.
- R12: The receive queue holds 16 bytes. A byte that arrives while the queue is full is discarded, and line status bit 0 stays set.
- R13: A write to offset 6 stores bits 7:4. Each bit of 3:0 becomes the OR of the written bit, the previous bit and the change of the matching upper bit. A read of offset 6 returns the value and then clears bits 3:0. Any set bit in 3:0 is the modem-status source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check the following on every cycle. A data write always produces the matching strobe one cycle later. A reported transmit-empty read always clears that pending flag. A read that empties the queue always removes both receive interrupts. irq never rises while all enables are zero. The queue never grows past its depth or accepts a push while full. The bench's scenarios are needed for the rest: priority resolution with several sources pending at once, divisor aliasing, the one-cycle lag of irq, arrival order through the queue, the modem delta arithmetic, and the dropped 17th byte.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_IDENT = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    localparam logic [3:0] IID_TIMEOUT = 4'hC;
    localparam logic [3:0] IID_RXDATA  = 4'h4;
    localparam logic [3:0] IID_TXEMPTY = 4'h2;
    localparam logic [3:0] IID_MODEM   = 4'h0;
    localparam logic [3:0] IID_NONE    = 4'h1;

    typedef struct packed {
        logic timeout;
        logic rxdata;
        logic txempty;
        logic modem;
    } pend_t;

endpackage

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o,
    output logic             full_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } qptr_t;

    qptr_t q_d, q_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic accept, take;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full_o  = (q_q.cnt == CW'(DEPTH));
    assign empty_o = (q_q.cnt == '0);
    assign head_o  = mem_q[q_q.rd];
    assign count_o = q_q.cnt;

    always_comb begin
        take   = pop_i && !empty_o;
        accept = push_i && (!full_o || take);
        q_d    = q_q;
        if (accept) q_d.wr = wrap_inc(q_q.wr);
        if (take)   q_d.rd = wrap_inc(q_q.rd);
        case ({accept, take})
            2'b10:   q_d.cnt = q_q.cnt + CW'(1);
            2'b01:   q_d.cnt = q_q.cnt - CW'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[q_q.wr] <= data_i;
    end

    // R12
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)));

endmodule

// File: rtl/serial_irq_resolver.sv
module serial_irq_resolver
    import serial_regfile_pkg::*;
(
    input  pend_t      pend_i,
    input  logic       rx_en_i,
    input  logic       tx_en_i,
    input  logic       ms_en_i,
    output logic [3:0] code_o,
    output logic       active_o
);

    always_comb begin
        if (pend_i.timeout && rx_en_i)      code_o = IID_TIMEOUT;
        else if (pend_i.rxdata && rx_en_i)  code_o = IID_RXDATA;
        else if (pend_i.txempty && tx_en_i) code_o = IID_TXEMPTY;
        else if (pend_i.modem && ms_en_i)   code_o = IID_MODEM;
        else                                code_o = IID_NONE;
        active_o = (code_o != IID_NONE);
    end

endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
    import serial_regfile_pkg::*;
#(
    parameter int RXQ_DEPTH = 16,
    localparam int CW = $clog2(RXQ_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       irq
);

    typedef struct packed {
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic [7:0] lctl;
        logic [7:0] mctl;
        logic [7:0] scr;
        logic [7:0] mstat;
        logic [3:0] ien;
        logic       fifo_on;
        logic       p_timeout;
        logic       p_rxdata;
        logic       p_txempty;
        logic       irq;
        logic       tx_vld;
        logic [7:0] tx_byte;
    } regs_t;

    regs_t r_d, r_q;

    logic          dlab;
    logic          data_rd;
    logic          last_pop;
    logic [7:0]    q_head;
    logic [CW-1:0] q_count;
    logic          q_full;
    logic          q_empty;
    pend_t         pend_now;
    logic [3:0]    iid_code;
    logic          iid_active;
    logic [3:0]    ms_delta;

    assign dlab     = r_q.lctl[7];
    assign data_rd  = bus_rd && (bus_addr == OFS_DATA) && !dlab;
    assign last_pop = data_rd && (q_count <= CW'(1));

    serial_rx_queue #(.DEPTH(RXQ_DEPTH), .WIDTH(8)) rxq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_valid),
        .data_i  (rx_byte),
        .pop_i   (data_rd),
        .head_o  (q_head),
        .count_o (q_count),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    always_comb begin
        pend_now.timeout = r_q.p_timeout;
        pend_now.rxdata  = r_q.p_rxdata;
        pend_now.txempty = r_q.p_txempty;
        pend_now.modem   = |r_q.mstat[3:0];
    end

    serial_irq_resolver res_i (
        .pend_i   (pend_now),
        .rx_en_i  (r_q.ien[0]),
        .tx_en_i  (r_q.ien[1]),
        .ms_en_i  (r_q.ien[3]),
        .code_o   (iid_code),
        .active_o (iid_active)
    );

    // Read mux, combinational from current state
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            case (bus_addr)
                OFS_DATA:  bus_rdata = dlab ? r_q.div_lo : (q_empty ? 8'h00 : q_head);
                OFS_IEN:   bus_rdata = dlab ? r_q.div_hi : {4'h0, r_q.ien};
                OFS_IDENT: bus_rdata = {{2{r_q.fifo_on}}, 2'b00, iid_code};
                OFS_LCTL:  bus_rdata = r_q.lctl;
                OFS_MCTL:  bus_rdata = r_q.mctl;
                OFS_LSTAT: bus_rdata = {1'b0, 1'b1, 1'b1, 4'h0, !q_empty};
                OFS_MSTAT: bus_rdata = r_q.mstat;
                default:   bus_rdata = r_q.scr;
            endcase
        end
    end

    // Next-state computation
    always_comb begin
        ms_delta = (r_q.mstat[7:4] ^ bus_wdata[7:4]) | r_q.mstat[3:0];
        r_d        = r_q;
        r_d.tx_vld = 1'b0;
        r_d.irq    = iid_active;

        if (bus_wr) begin
            case (bus_addr)
                OFS_DATA: begin
                    if (dlab) begin
                        r_d.div_lo = bus_wdata;
                    end else begin
                        r_d.tx_vld    = 1'b1;
                        r_d.tx_byte   = bus_wdata;
                        r_d.p_txempty = 1'b1;
                    end
                end
                OFS_IEN: begin
                    if (dlab) begin
                        r_d.div_hi = bus_wdata;
                    end else begin
                        if (!r_q.ien[1] && bus_wdata[1]) r_d.p_txempty = 1'b1;
                        r_d.ien = bus_wdata[3:0];
                    end
                end
                OFS_IDENT: r_d.fifo_on = bus_wdata[0];
                OFS_LCTL:  r_d.lctl    = bus_wdata;
                OFS_MCTL:  r_d.mctl    = bus_wdata;
                OFS_MSTAT: r_d.mstat   = {bus_wdata[7:4], bus_wdata[3:0] | ms_delta};
                OFS_SCR:   r_d.scr     = bus_wdata;
                default:   ;
            endcase
        end

        if (bus_rd) begin
            if (last_pop) begin
                r_d.p_timeout = 1'b0;
                r_d.p_rxdata  = 1'b0;
            end
            if (bus_addr == OFS_IDENT && iid_code == IID_TXEMPTY)
                r_d.p_txempty = 1'b0;
            if (bus_addr == OFS_MSTAT)
                r_d.mstat[3:0] = 4'h0;
        end

        if (rx_valid) begin
            if (r_q.fifo_on) r_d.p_timeout = 1'b1;
            else             r_d.p_rxdata  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.p_txempty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid = r_q.tx_vld;
    assign tx_byte  = r_q.tx_byte;
    assign irq      = r_q.irq;

    // R9
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA && !dlab) |=> (tx_valid && tx_byte == $past(bus_wdata)));

    // R6
    ident_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_IDENT && bus_rdata[3:0] == IID_TXEMPTY) |=> !r_q.p_txempty);

    // R8
    drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && q_count <= CW'(1) && !rx_valid) |=> (!r_q.p_timeout && !r_q.p_rxdata && q_empty));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ien == 4'h0) |=> !irq);

    // R3
    ien_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_IEN && !dlab) |-> (bus_rdata[7:4] == 4'h0));

endmodule

// File: tb/serial_regfile_tb_top.sv
module serial_regfile_tb_top;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_RX = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 49;
    localparam vec_t VEC [NVEC] = '{
        '{OP_RD, 3'd2, 8'h00, 8'h01, 4'd1},   // R1 ident idle
        '{OP_RD, 3'd5, 8'h00, 8'h60, 4'd1},   // R1 line status
        '{OP_RD, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 enable
        '{OP_WR, 3'd3, 8'h80, 8'h00, 4'd2},   // R2 divisor access on
        '{OP_WR, 3'd0, 8'h34, 8'h00, 4'd2},
        '{OP_WR, 3'd1, 8'h12, 8'h00, 4'd2},
        '{OP_RD, 3'd0, 8'h00, 8'h34, 4'd2},
        '{OP_RD, 3'd1, 8'h00, 8'h12, 4'd2},
        '{OP_WR, 3'd3, 8'h03, 8'h00, 4'd11},  // R11 line control
        '{OP_RD, 3'd3, 8'h00, 8'h03, 4'd11},
        '{OP_RD, 3'd1, 8'h00, 8'h00, 4'd2},   // R2 enable untouched
        '{OP_WR, 3'd1, 8'hFF, 8'h00, 4'd3},   // R3
        '{OP_RD, 3'd1, 8'h00, 8'h0F, 4'd3},
        '{OP_RD, 3'd2, 8'h00, 8'h02, 4'd4},   // R4 tx empty from reset
        '{OP_RD, 3'd2, 8'h00, 8'h01, 4'd6},   // R6 cleared by read
        '{OP_WR, 3'd0, 8'h41, 8'h00, 4'd9},   // R9
        '{OP_RD, 3'd2, 8'h00, 8'h02, 4'd9},
        '{OP_RD, 3'd2, 8'h00, 8'h01, 4'd6},
        '{OP_RX, 3'd0, 8'h55, 8'h00, 4'd7},   // R7
        '{OP_RD, 3'd5, 8'h00, 8'h61, 4'd7},
        '{OP_RD, 3'd2, 8'h00, 8'h04, 4'd7},
        '{OP_RX, 3'd0, 8'h66, 8'h00, 4'd8},   // R8
        '{OP_RD, 3'd0, 8'h00, 8'h55, 4'd8},
        '{OP_RD, 3'd2, 8'h00, 8'h04, 4'd8},
        '{OP_RD, 3'd0, 8'h00, 8'h66, 4'd8},
        '{OP_RD, 3'd5, 8'h00, 8'h60, 4'd8},
        '{OP_RD, 3'd2, 8'h00, 8'h01, 4'd8},
        '{OP_RD, 3'd0, 8'h00, 8'h00, 4'd8},
        '{OP_WR, 3'd2, 8'h01, 8'h00, 4'd6},   // R6 fifo bit
        '{OP_RX, 3'd0, 8'h77, 8'h00, 4'd7},
        '{OP_RD, 3'd2, 8'h00, 8'hCC, 4'd7},
        '{OP_RD, 3'd0, 8'h00, 8'h77, 4'd8},
        '{OP_RD, 3'd2, 8'h00, 8'hC1, 4'd6},
        '{OP_WR, 3'd2, 8'h00, 8'h00, 4'd6},
        '{OP_WR, 3'd5, 8'h00, 8'h00, 4'd11},  // R11 ignored write
        '{OP_RD, 3'd5, 8'h00, 8'h60, 4'd11},
        '{OP_WR, 3'd7, 8'hA5, 8'h00, 4'd11},
        '{OP_RD, 3'd7, 8'h00, 8'hA5, 4'd11},
        '{OP_WR, 3'd4, 8'h1F, 8'h00, 4'd11},
        '{OP_RD, 3'd4, 8'h00, 8'h1F, 4'd11},
        '{OP_WR, 3'd6, 8'hB0, 8'h00, 4'd13},  // R13
        '{OP_RD, 3'd2, 8'h00, 8'h00, 4'd13},
        '{OP_RD, 3'd6, 8'h00, 8'hBB, 4'd13},
        '{OP_RD, 3'd6, 8'h00, 8'hB0, 4'd13},
        '{OP_RD, 3'd2, 8'h00, 8'h01, 4'd13},
        '{OP_WR, 3'd1, 8'h00, 8'h00, 4'd10},  // R10
        '{OP_WR, 3'd1, 8'h02, 8'h00, 4'd10},
        '{OP_RD, 3'd2, 8'h00, 8'h02, 4'd10},
        '{OP_RD, 3'd2, 8'h00, 8'h01, 4'd10}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    serial_regfile dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic rd, input logic [2:0] a,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] unused_q;
        bus_op(1'b1, 1'b0, a, d, unused_q);
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] q;
        bus_op(1'b0, 1'b1, a, 8'h00, q);
        check(tag, q, exp);
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        check("R1 tx_valid after reset", {7'b0, tx_valid}, 8'h00);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_WR: wr(VEC[i].addr, VEC[i].data);
                OP_RX: rx_push(VEC[i].data);
                default: begin
                    bus_op(1'b0, 1'b1, VEC[i].addr, 8'h00, q);
                    check($sformatf("R%0d vector %0d", VEC[i].req, i), q, VEC[i].exp);
                end
            endcase
        end

        // R5 / R9: irq lag and transmit strobe
        wr(3'd1, 8'h00);
        @(posedge clk); #1;
        check("R5 irq masked", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'h11);
        check("R9 strobe high", {7'b0, tx_valid}, 8'h01);
        check("R9 strobe byte", tx_byte, 8'h11);
        @(posedge clk); #1;
        check("R9 strobe one cycle", {7'b0, tx_valid}, 8'h00);
        check("R5 irq still masked", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'h02);
        check("R5 irq not yet high", {7'b0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R5 irq high after lag", {7'b0, irq}, 8'h01);
        rd_chk("R6 ident tx empty", 3'd2, 8'h02);
        check("R5 irq holds one cycle", {7'b0, irq}, 8'h01);
        @(posedge clk); #1;
        check("R5 irq falls after lag", {7'b0, irq}, 8'h00);

        // R4: all four sources pending at once
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h0F);
        wr(3'd0, 8'h22);
        wr(3'd6, 8'h10);
        rx_push(8'h33);
        rd_chk("R4 timeout wins", 3'd2, 8'hCC);
        wr(3'd2, 8'h00);
        rd_chk("R8 pop", 3'd0, 8'h33);
        rd_chk("R4 tx empty next", 3'd2, 8'h02);
        rd_chk("R4 modem last", 3'd2, 8'h00);
        rd_chk("R13 delta merge", 3'd6, 8'h1A);
        rd_chk("R4 none", 3'd2, 8'h01);

        // R12: overflow drops the 17th byte
        wr(3'd1, 8'h00);
        for (int k = 0; k < 17; k++) rx_push(8'h80 + 8'(k));
        rd_chk("R12 ready while full", 3'd5, 8'h61);
        for (int k = 0; k < 16; k++) rd_chk("R12 order", 3'd0, 8'h80 + 8'(k));
        rd_chk("R12 dropped byte", 3'd0, 8'h00);
        rd_chk("R12 drained", 3'd5, 8'h60);

        finish_run();
    end

endmodule